// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block produces the two mailbox interrupts of a shared memory that has a left and a right access port, 4096 words of 16 bits by default. The two highest word addresses act as mailboxes, one per direction: the left mailbox is 0xFFE and the right mailbox is 0xFFF. When one port writes the mailbox that belongs to the other port, that other port receives an interrupt. The receiving port acknowledges it by reading its own mailbox.

The block watches each port's chip select, read/write select, output enable and address. It drives one active-low, registered interrupt output per port. It holds no data. The mailbox words stay ordinary memory words in the array beside it, so their 16-bit contents are whatever software stores there.

An enable input selects the mode. When it is low, both mailbox addresses are plain memory and neither interrupt can assert.

Each interrupt flag is a two-state machine with the states FLAG_IDLE and FLAG_PENDING. The transitions are:
- T_RAISE: FLAG_IDLE to FLAG_PENDING on a set event.
- T_ACK: FLAG_PENDING to FLAG_IDLE on a clear event with no set event in the same cycle.
- T_DISABLE: any state to FLAG_IDLE while the enable input is low.

In every other case the state is held.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: If the right port has cs_n=0 and rw_n=0 at address 0xFFE at a clock edge while enabled, then l_irq_n is 0 after that edge.
- R2: If the left port has cs_n=0 and rw_n=0 at address 0xFFF at a clock edge while enabled, then r_irq_n is 0 after that edge.
- R3: A set needs both cs_n=0 and rw_n=0 on the writing port. A read (rw_n=1), or an access with cs_n=1, to the other port's mailbox leaves that port's flag unchanged.
- R4: An access by the left port to 0xFFE with cs_n=0 and oe_n=0, whatever rw_n is, clears l_irq_n to 1 at that edge.
- R5: An access by the right port to 0xFFF with cs_n=0 and oe_n=0, whatever rw_n is, clears r_irq_n to 1 at that edge.
- R6: Accesses to any address other than the two mailboxes leave both flags unchanged. A port writing the other port's mailbox does not affect its own flag.
- R7: While irq_en is 0, both outputs are 1 on the following edge and mailbox accesses set nothing. After irq_en returns to 1, both flags start cleared.
- R8: If a set and a clear of the same flag fall on the same edge, the flag ends set.
- R9: After reset, l_irq_n and r_irq_n are both 1.
- R10: A raised flag stays raised, through any number of cycles, until a clear event or irq_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | 1 = mailbox interrupts active, 0 = mailboxes are plain memory |
| l_cs_n | input | 1 | Left port chip select, active low |
| l_rw_n | input | 1 | Left port read/write select, 0 = write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 12 | Left port word address |
| r_cs_n | input | 1 | Right port chip select, active low |
| r_rw_n | input | 1 | Right port read/write select, 0 = write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 12 | Right port word address |
| l_irq_n | output | 1 | Left port interrupt, active low, registered |
| r_irq_n | output | 1 | Right port interrupt, active low, registered |

## Verification
The set and the clear of one flag can land on the same edge. For the left flag, this happens when the right port writes 0xFFE while the left port reads 0xFFE with output enable low; the right flag has the mirror case. The bench reaches this through a sweep. The sweep first places the flags in each of the four starting states. It then applies every combination of the two ports' control levels, each port addressing the left mailbox, the right mailbox or an unrelated word, under both enable levels. On each case it compares both outputs with a value computed from the requirements, where set outranks clear. Directed cases also pin the collision down by name with the flag starting both idle and pending.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  logic              en,
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              peer_post,
    output logic              own_ack
);
    logic selected;

    always_comb begin
        selected  = en && !cs_n;
        // write to the opposite port's mailbox raises that port's flag
        peer_post = selected && !rw_n && (addr == PEER_BOX);
        // enabled output on own mailbox acknowledges, rw_n ignored
        own_ack   = selected && !oe_n && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq_n
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = FLAG_IDLE;                        // T_DISABLE
        end else begin
            unique case (state_q)
                FLAG_IDLE:    if (set_evt) state_d = FLAG_PENDING;          // T_RAISE
                FLAG_PENDING: if (clr_evt && !set_evt) state_d = FLAG_IDLE; // T_ACK
                default:      state_d = FLAG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= (state_d != FLAG_PENDING);
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              l_cs_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] BOX_R = '1;
    localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

    logic [NUM_PORTS-1:0]             cs_n_v, rw_n_v, oe_n_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             post_v, ack_v, irq_n_v;

    always_comb begin
        cs_n_v[PORT_L] = l_cs_n;  cs_n_v[PORT_R] = r_cs_n;
        rw_n_v[PORT_L] = l_rw_n;  rw_n_v[PORT_R] = r_rw_n;
        oe_n_v[PORT_L] = l_oe_n;  oe_n_v[PORT_R] = r_oe_n;
        addr_v[PORT_L] = l_addr;  addr_v[PORT_R] = r_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == PORT_L) ? BOX_L : BOX_R;
        localparam logic [ADDR_W-1:0] PEER = (p == PORT_L) ? BOX_R : BOX_L;

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .en        (irq_en),
            .cs_n      (cs_n_v[p]),
            .rw_n      (rw_n_v[p]),
            .oe_n      (oe_n_v[p]),
            .addr      (addr_v[p]),
            .peer_post (post_v[p]),
            .own_ack   (ack_v[p])
        );

        mbx_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (irq_en),
            .set_evt (post_v[NUM_PORTS-1-p]),
            .clr_evt (ack_v[p]),
            .irq_n   (irq_n_v[p])
        );
    end

    assign l_irq_n = irq_n_v[PORT_L];
    assign r_irq_n = irq_n_v[PORT_R];
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              l_cs_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_cs_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] RB = '1;
    localparam logic [ADDR_W-1:0] LB = RB - 1'b1;

    logic wr_lb, wr_rb, rd_lb, rd_rb;
    assign wr_lb = irq_en && !r_cs_n && !r_rw_n && (r_addr == LB);
    assign wr_rb = irq_en && !l_cs_n && !l_rw_n && (l_addr == RB);
    assign rd_lb = irq_en && !l_cs_n && !l_oe_n && (l_addr == LB);
    assign rd_rb = irq_en && !r_cs_n && !r_oe_n && (r_addr == RB);

    a_r1_left_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lb |=> !l_irq_n);
    a_r2_right_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rb |=> !r_irq_n);
    a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lb && !wr_lb) |=> l_irq_n);
    a_r5_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rb && !wr_rb) |=> r_irq_n);
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> (l_irq_n && r_irq_n));
    a_r10_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !wr_lb && !rd_lb) |=> $stable(l_irq_n));
    a_r10_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !wr_rb && !rd_rb) |=> $stable(r_irq_n));
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;
    localparam int AW = 12;
    localparam logic [AW-1:0] LB = 12'hFFE;
    localparam logic [AW-1:0] RB = 12'hFFF;
    localparam logic [AW-1:0] OTHER = 12'h3A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_en = 1'b1;
    logic l_cs_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
    logic r_cs_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(AW)) dut (.*);

    task automatic check(input string tag, input logic l_exp, input logic r_exp);
        n_tests++;
        if (l_irq_n !== l_exp || r_irq_n !== r_exp) begin
            n_fail++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                     tag, l_irq_n, r_irq_n, l_exp, r_exp);
        end
    endtask

    task automatic drive(input logic en,
                         input logic lc, input logic lr, input logic lo, input logic [AW-1:0] la,
                         input logic rc, input logic rr, input logic ro, input logic [AW-1:0] ra);
        irq_en = en;
        l_cs_n = lc; l_rw_n = lr; l_oe_n = lo; l_addr = la;
        r_cs_n = rc; r_rw_n = rr; r_oe_n = ro; r_addr = ra;
    endtask

    // one cycle: apply at negedge, result visible by next negedge
    task automatic cyc(input logic en,
                       input logic lc, input logic lr, input logic lo, input logic [AW-1:0] la,
                       input logic rc, input logic rr, input logic ro, input logic [AW-1:0] ra);
        drive(en, lc, lr, lo, la, rc, rr, ro, ra);
        @(negedge clk);
    endtask

    task automatic idle_cyc();
        cyc(1'b1, 1'b1, 1'b1, 1'b1, OTHER, 1'b1, 1'b1, 1'b1, OTHER);
    endtask

    // bring flags to a known pending state pl/pr (1 = pending)
    task automatic prep(input logic pl, input logic pr);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, LB, 1'b0, 1'b1, 1'b0, RB);   // both acknowledge
        cyc(1'b1, !pr, 1'b0, 1'b1, RB, !pl, 1'b0, 1'b1, LB);     // posts, oe high
    endtask

    function automatic logic [AW-1:0] sel_addr(input int k);
        return (k == 0) ? LB : ((k == 1) ? RB : OTHER);
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R9 reset", 1'b1, 1'b1);
        rst_n = 1'b1;
        idle_cyc();
        check("R9 after release", 1'b1, 1'b1);

        // R1: right writes 0xFFE
        cyc(1'b1, 1'b1, 1'b1, 1'b1, OTHER, 1'b0, 1'b0, 1'b1, LB);
        check("R1 left set", 1'b0, 1'b1);
        // R10: hold
        for (int i = 0; i < 5; i++) idle_cyc();
        check("R10 left held", 1'b0, 1'b1);
        // R4: left read-clear with rw_n=0
        cyc(1'b1, 1'b0, 1'b0, 1'b0, LB, 1'b1, 1'b1, 1'b1, OTHER);
        check("R4 left clear rw0", 1'b1, 1'b1);
        // R2 and R6: left writes 0xFFF, own flag unaffected
        cyc(1'b1, 1'b0, 1'b0, 1'b1, RB, 1'b1, 1'b1, 1'b1, OTHER);
        check("R2 right set", 1'b1, 1'b0);
        check("R6 writer flag untouched", 1'b1, 1'b0);
        // R3: read of the other mailbox, and cs high write, do nothing
        cyc(1'b1, 1'b1, 1'b0, 1'b1, LB, 1'b0, 1'b1, 1'b1, LB);
        check("R3 no set on read or cs high", 1'b1, 1'b0);
        // R6: other addresses do not clear
        cyc(1'b1, 1'b0, 1'b1, 1'b0, OTHER, 1'b0, 1'b1, 1'b0, OTHER);
        check("R6 other addr no clear", 1'b1, 1'b0);
        // R5: right read-clear with rw_n=1
        cyc(1'b1, 1'b1, 1'b1, 1'b1, OTHER, 1'b0, 1'b1, 1'b0, RB);
        check("R5 right clear rw1", 1'b1, 1'b1);
        // R8: set and clear same edge, from idle and from pending
        cyc(1'b1, 1'b0, 1'b1, 1'b0, LB, 1'b0, 1'b0, 1'b1, LB);
        check("R8 left collision from idle", 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, RB, 1'b0, 1'b1, 1'b0, RB);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, RB, 1'b0, 1'b1, 1'b0, RB);
        check("R8 right collision from pending", 1'b0, 1'b0);
        // R7: disable clears and blocks, re-enable starts clear
        cyc(1'b0, 1'b0, 1'b0, 1'b1, RB, 1'b0, 1'b0, 1'b1, LB);
        check("R7 disabled", 1'b1, 1'b1);
        idle_cyc();
        check("R7 re-enabled clear", 1'b1, 1'b1);

        // sweep: start states x enable x all port control/address combos
        for (int st = 0; st < 4; st++) begin
            for (int en = 0; en < 2; en++) begin
                for (int lc = 0; lc < 64; lc++) begin
                    for (int rc = 0; rc < 64; rc++) begin
                        logic pl, pr, l_cs, l_rw, l_oe, r_cs, r_rw, r_oe;
                        logic [AW-1:0] la, ra;
                        logic sl, sr, cl, cr, el, er;
                        string tag;
                        if ((lc >> 3) >= 3 || (rc >> 3) >= 3) continue;
                        pl = st[0]; pr = st[1];
                        l_cs = lc[0]; l_rw = lc[1]; l_oe = lc[2]; la = sel_addr(lc >> 3);
                        r_cs = rc[0]; r_rw = rc[1]; r_oe = rc[2]; ra = sel_addr(rc >> 3);
                        prep(pl, pr);
                        cyc(en[0], l_cs, l_rw, l_oe, la, r_cs, r_rw, r_oe, ra);
                        sl = !r_cs && !r_rw && (ra == LB);
                        sr = !l_cs && !l_rw && (la == RB);
                        cl = !l_cs && !l_oe && (la == LB);
                        cr = !r_cs && !r_oe && (ra == RB);
                        el = en[0] && (sl || (pl && !cl));
                        er = en[0] && (sr || (pr && !cr));
                        if (en == 0)                          tag = "R7 sweep";
                        else if ((sl && cl) || (sr && cr))    tag = "R8 sweep";
                        else if (sl || sr)                    tag = "R1 R2 sweep";
                        else if (cl || cr)                    tag = "R4 R5 sweep";
                        else                                  tag = "R3 R6 R10 sweep";
                        check(tag, !el, !er);
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule